// File: doc/BRIEF.md
# Synchronous Successive-Approximation Step Controller

This block is the digital sequencer for one slice of a 6-bit successive-approximation converter. It runs a binary search over a fixed frame of seven master-clock periods. The first period of each frame is the sampling window. In each of the six periods that follow, the block places a trial 1 on one bit of the capacitor-DAC drive word and resolves the bit tried in the period before. To do this it uses the latched comparator decision that is presented during that period.

Each bit of the drive word has its own stage register and its own pending flag. While the bits are unresolved, the pending flags are high. They drop one per clock from the MSB downward, and a stage whose flag is low keeps its value for the rest of the frame. Every register is clocked on the same edge and has only a synchronous clear. At the end of the seventh period, an internal frame clear re-arms all stages. On that same edge, a separate output register captures the LSB straight from the comparator together with the five bits already resolved, and it raises a one-cycle done strobe.

Top module: `sar_step_ctrl`

## Requirements
- R1: After reset is released, the block runs repeating 7-cycle frames. `sample_ph` is 1 in the first cycle of each frame and 0 in the other six. While `rst` is high, the block stays in the sampling cycle.
- R2: While `sample_ph` is 1, `bit_drv` is 000000, and the value of `cmp_in` has no effect on any later output.
- R3: In the second cycle of a frame, `bit_drv` is 100000: the MSB (bit 5) is at its trial 1 and bits 4..0 are 0.
- R4: In frame cycle k (k = 3..7), bit 7-k is at trial 1, the bits below it are 0, and bit 8-k takes the value NOT `cmp_in` as seen during cycle k-1. A `cmp_in` of 1 clears the tried bit and a `cmp_in` of 0 keeps it.
- R5: A bit that has been resolved keeps its value until the end of the frame.
- R6: `bit_drv_n` is always the bitwise complement of `bit_drv`.
- R7: At the end of cycle 7, `code_out` loads bits 5..1 from the resolved drive bits and bit 0 from NOT `cmp_in` as seen during cycle 7. Bit 5 of `code_out` is the MSB.
- R8: `code_vld` is high for exactly one cycle: the sampling cycle that follows a completed frame. `code_out` holds its value until the next frame completes.
- R9: A synchronous reset, including one asserted in the middle of a conversion, gives `bit_drv` = 0, `sample_ph` = 1, `code_out` = 0 and `code_vld` = 0 at the next clock edge. The next frame then starts from its sampling cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; every register samples on its rising edge |
| rst | input | 1 | Synchronous active-high reset and restart |
| cmp_in | input | 1 | Latched comparator decision; 1 means the positive DAC node is above the negative one |
| bit_drv | output | 6 | True-form trial/decided bits to the DAC |
| bit_drv_n | output | 6 | Complement-form bits to the DAC |
| sample_ph | output | 1 | High during the sampling cycle of each frame |
| code_out | output | 6 | Last completed conversion result |
| code_vld | output | 1 | One-cycle done strobe for a new `code_out` |

## Verification
Frames in which every decision is 1 and frames in which every decision is 0 yield codes 000000 and 111111. These two codes show whether the polarity of the comparator is right and whether each stage reaches its decision at all. An alternating decision pattern shows whether each decision lands on the right bit position, since a shift by one period would produce the inverted code. Random decision streams, including random values driven during the sampling cycle, show whether decided bits stay put and whether the sampling cycle ignores the comparator. A reset placed in the middle of a frame shows whether a partial search is thrown away and whether the old code is cleared.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;

    localparam int SAR_BITS = 6;

    // Position of the current cycle inside a conversion frame
    typedef enum logic [1:0] {
        POS_SAMPLE = 2'd0,
        POS_STEP   = 2'd1,
        POS_FINAL  = 2'd2
    } frame_pos_e;

    // State held by one bit stage
    typedef struct packed {
        logic drv;   // trial or decided bit value
        logic pend;  // 1 while the bit is still unresolved
    } bit_state_t;

    localparam bit_state_t BIT_IDLE = '{drv: 1'b0, pend: 1'b1};

    // Resolution of a bit under trial: a comparator 1 clears it
    function automatic logic resolve_bit(input logic cur, input logic cmp);
        return cur & ~cmp;
    endfunction

endpackage

// File: rtl/sar_frame_cnt.sv
module sar_frame_cnt
    import sar_ctrl_pkg::*;
#(
    parameter int FRAME_LEN = SAR_BITS + 1
) (
    input  logic       clk,
    input  logic       rst,
    output frame_pos_e pos
);
    localparam int CW = $clog2(FRAME_LEN);
    localparam logic [CW-1:0] LAST = CW'(FRAME_LEN - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        if (cnt_q == '0) begin
            pos = POS_SAMPLE;
        end else if (cnt_q == LAST) begin
            pos = POS_FINAL;
        end else begin
            pos = POS_STEP;
        end
    end

endmodule

// File: rtl/sar_bit_stage.sv
module sar_bit_stage
    import sar_ctrl_pkg::*;
#(
    parameter bit IS_TOP = 1'b0
) (
    input  logic clk,
    input  logic clear,        // frame clear or reset
    input  logic sampling,     // sampling cycle of the frame
    input  logic cmp,          // comparator decision
    input  logic pend_above,   // pending flag of the next higher stage
    input  logic trial_above,  // next higher stage is under trial now
    output logic drv,
    output logic pend,
    output logic trial         // this stage is under trial now
);
    bit_state_t st_q;

    // A stage is tried when it is still pending and every stage above is done
    assign trial = st_q.pend & ~sampling & (IS_TOP ? 1'b1 : ~pend_above);

    always_ff @(posedge clk) begin
        if (clear) begin
            st_q <= BIT_IDLE;
        end else if (sampling) begin
            st_q.drv  <= IS_TOP;
            st_q.pend <= 1'b1;
        end else if (trial) begin
            st_q.drv  <= resolve_bit(st_q.drv, cmp);
            st_q.pend <= 1'b0;
        end else if (trial_above) begin
            st_q.drv  <= 1'b1;
        end
    end

    assign drv  = st_q.drv;
    assign pend = st_q.pend;

endmodule

// File: rtl/sar_code_reg.sv
module sar_code_reg #(
    parameter int NBITS = sar_ctrl_pkg::SAR_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic             cmp,
    input  logic [NBITS-1:1] upper_bits,
    output logic [NBITS-1:0] code,
    output logic             vld
);
    always_ff @(posedge clk) begin
        if (rst) begin
            code <= '0;
            vld  <= 1'b0;
        end else if (capture) begin
            code <= {upper_bits, ~cmp};
            vld  <= 1'b1;
        end else begin
            vld  <= 1'b0;
        end
    end

endmodule

// File: rtl/sar_step_ctrl.sv
module sar_step_ctrl
    import sar_ctrl_pkg::*;
#(
    parameter int NBITS = SAR_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmp_in,
    output logic [NBITS-1:0] bit_drv,
    output logic [NBITS-1:0] bit_drv_n,
    output logic             sample_ph,
    output logic [NBITS-1:0] code_out,
    output logic             code_vld
);
    localparam int FRAME_LEN = NBITS + 1;

    frame_pos_e       pos;
    logic             frame_clr;
    logic [NBITS-1:0] drv_w;
    logic [NBITS-1:0] pend_w;
    logic [NBITS-1:0] trial_w;

    sar_frame_cnt #(.FRAME_LEN(FRAME_LEN)) i_cnt (
        .clk (clk),
        .rst (rst),
        .pos (pos)
    );

    assign sample_ph = (pos == POS_SAMPLE);
    assign frame_clr = rst | (pos == POS_FINAL);

    for (genvar i = 0; i < NBITS; i++) begin : g_stage
        logic p_above;
        logic t_above;
        if (i == NBITS - 1) begin : g_top
            assign p_above = 1'b0;
            assign t_above = 1'b0;
        end else begin : g_low
            assign p_above = pend_w[i+1];
            assign t_above = trial_w[i+1];
        end
        sar_bit_stage #(.IS_TOP(i == NBITS - 1)) i_stage (
            .clk         (clk),
            .clear       (frame_clr),
            .sampling    (sample_ph),
            .cmp         (cmp_in),
            .pend_above  (p_above),
            .trial_above (t_above),
            .drv         (drv_w[i]),
            .pend        (pend_w[i]),
            .trial       (trial_w[i])
        );
    end

    sar_code_reg #(.NBITS(NBITS)) i_code (
        .clk        (clk),
        .rst        (rst),
        .capture    (pos == POS_FINAL),
        .cmp        (cmp_in),
        .upper_bits (drv_w[NBITS-1:1]),
        .code       (code_out),
        .vld        (code_vld)
    );

    assign bit_drv   = drv_w;
    assign bit_drv_n = ~drv_w;

endmodule

// File: rtl/sar_step_chk.sv
module sar_step_chk #(
    parameter int NBITS = sar_ctrl_pkg::SAR_BITS
) (
    input logic             clk,
    input logic             rst,
    input logic             cmp_in,
    input logic [NBITS-1:0] bit_drv,
    input logic             sample_ph,
    input logic [NBITS-1:0] code_out,
    input logic             code_vld
);
    assert_sample_single_R1: assert property (@(posedge clk) disable iff (rst)
        sample_ph |=> !sample_ph);

    assert_sample_clear_R2: assert property (@(posedge clk) disable iff (rst)
        sample_ph |-> bit_drv == '0);

    assert_msb_trial_R3: assert property (@(posedge clk) disable iff (rst)
        sample_ph |=> bit_drv == {1'b1, {(NBITS-1){1'b0}}});

    assert_code_load_R7: assert property (@(posedge clk) disable iff (rst)
        code_vld |-> code_out == {$past(bit_drv[NBITS-1:1]), ~$past(cmp_in)});

    assert_done_in_sample_R8: assert property (@(posedge clk) disable iff (rst)
        code_vld |-> sample_ph);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        code_vld |=> !code_vld);

    assert_code_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !code_vld |-> $stable(code_out));

    assert_reset_state_R9: assert property (@(posedge clk)
        $past(rst) |-> (sample_ph && bit_drv == '0 && code_out == '0 && !code_vld));

endmodule

bind sar_step_ctrl sar_step_chk #(.NBITS(NBITS)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .cmp_in    (cmp_in),
    .bit_drv   (bit_drv),
    .sample_ph (sample_ph),
    .code_out  (code_out),
    .code_vld  (code_vld)
);

// File: tb/test_sar_step_ctrl.sv
module test_sar_step_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmp_in = 1'b0;
    logic [5:0] bit_drv;
    logic [5:0] bit_drv_n;
    logic       sample_ph;
    logic [5:0] code_out;
    logic       code_vld;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // reference model state
    int         m_ph = 0;
    logic [5:0] m_dec = '0;
    logic [5:0] m_code = '0;
    logic       m_vld = 1'b0;
    logic       m_after_rst = 1'b1;

    always #2.5 clk = ~clk;

    sar_step_ctrl i_sar_step_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmp_in    (cmp_in),
        .bit_drv   (bit_drv),
        .bit_drv_n (bit_drv_n),
        .sample_ph (sample_ph),
        .code_out  (code_out),
        .code_vld  (code_vld)
    );

    function automatic logic [5:0] exp_bits(input int ph, input logic [5:0] dec);
        logic [5:0] r;
        r = '0;
        if (ph != 0) begin
            for (int i = 0; i < 6; i++) begin
                if (i > 6 - ph) r[i] = dec[i];
                else if (i == 6 - ph) r[i] = 1'b1;
            end
        end
        return r;
    endfunction

    function automatic logic [5:0] upper_mask(input int ph);
        logic [5:0] r;
        r = '0;
        for (int i = 0; i < 6; i++) begin
            if (ph >= 2 && i > 6 - ph) r[i] = 1'b1;
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b (frame cycle %0d)", tag, act, exp, m_ph + 1);
        end
    endtask

    task automatic check_all();
        if (m_after_rst) begin
            chk("R9 sample", {5'd0, sample_ph}, 6'd1);
            chk("R9 bits", bit_drv, 6'd0);
            chk("R9 code", code_out, 6'd0);
            chk("R9 done", {5'd0, code_vld}, 6'd0);
        end
        chk("R1 sample flag", {5'd0, sample_ph}, {5'd0, m_ph == 0});
        if (m_ph == 0)      chk("R2 bits zero", bit_drv, 6'd0);
        else if (m_ph == 1) chk("R3 msb trial", bit_drv, 6'b100000);
        else                chk("R4 step bits", bit_drv, exp_bits(m_ph, m_dec));
        if (m_ph >= 2)
            chk("R5 decided hold", bit_drv & upper_mask(m_ph), m_dec & upper_mask(m_ph));
        chk("R6 complement", bit_drv_n, ~exp_bits(m_ph, m_dec));
        chk("R7 code", code_out, m_code);
        chk("R8 done", {5'd0, code_vld}, {5'd0, m_vld});
    endtask

    task automatic step(input logic r, input logic c);
        @(negedge clk);
        check_all();
        rst = r;
        cmp_in = c;
        if (r) begin
            m_ph = 0;
            m_dec = '0;
            m_code = '0;
            m_vld = 1'b0;
            m_after_rst = 1'b1;
        end else begin
            m_after_rst = 1'b0;
            if (m_ph >= 1) m_dec[6 - m_ph] = ~c;
            m_vld = (m_ph == 6);
            if (m_ph == 6) m_code = m_dec;
            if (m_ph == 0) m_dec = '0;
            m_ph = (m_ph + 1) % 7;
        end
    endtask

    // one frame: sampling-cycle value then six decisions, LSB decision last
    task automatic frame(input logic samp_c, input logic [5:0] decs);
        step(1'b0, samp_c);
        for (int k = 5; k >= 0; k--) step(1'b0, decs[k]);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got %0d cycles expected at most 20000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed_sink;
        seed_sink = $urandom(32'd4711);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        step(1'b1, 1'b0);                 // R9 reset state seen here
        // directed: all decisions 1 -> code 000000 (R4, R7)
        frame(1'b1, 6'b111111);
        // directed: all decisions 0 -> code 111111 (R4, R7)
        frame(1'b0, 6'b000000);
        // directed: alternating -> position check (R4, R7)
        frame(1'b1, 6'b101010);
        frame(1'b0, 6'b010101);
        // reset in the middle of a frame (R9)
        step(1'b0, 1'b0);
        step(1'b0, 1'b1);
        step(1'b0, 1'b0);
        step(1'b1, 1'b1);
        step(1'b1, 1'b0);
        frame(1'b1, 6'b110011);
        // random decisions and random sampling-cycle input (R2, R5, R8)
        for (int f = 0; f < 60; f++) begin
            frame(1'($urandom_range(0, 1)), 6'($urandom_range(0, 63)));
        end
        step(1'b0, 1'b0);                 // check final completion strobe
        step(1'b0, 1'b0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule